// File: doc/BRIEF.md
# I2C Target Data-Line Hold and Clock-Stretch Timer

This block times the data line of an I2C target against the clock line that the bus controller drives. The raw clock level from the pad passes through a synchronizer, and the block watches for each high-to-low transition. After a short minimum delay, it presents the next data bit. It must do so before a mode-dependent deadline that keeps the new level clear of the data setup interval ahead of the next rising clock edge. Upstream byte logic offers each bit with a valid/value pair. The block acknowledges the bit with a one-cycle take pulse in the same cycle that the data line changes.

If no bit is offered by the deadline, the block holds the clock line low to stretch it. Once the bit arrives, it changes the data line first and keeps the clock low for a full setup interval before releasing it. Both pads are open-drain, so each output is a drive-low enable: a 1 pulls the wire low and a 0 releases it. A mode input picks standard-mode or fast-mode limits. The mode is captured at each clock falling edge. Every limit is a cycle count derived at elaboration from the clock-frequency parameter. At the default 200 MHz, the limits are:

| Mode | Hold deadline | Setup | Low period |
|------|---------------|-------|------------|
| Standard | 690 cycles | 50 cycles | 940 cycles |
| Fast | 180 cycles | 20 cycles | 260 cycles |

Top module: `sda_hold_timer`

## Requirements
- R1: During and after reset, with the clock pad high, both drive-low outputs are 0 (released) and `bit_taken` is 0.
- R2: `sda_drive_low` changes only in a cycle whose synchronized clock level is low, and a changed value always equals the inverse of the offered `bit_value`: a value of 1 releases the line and a value of 0 drives it low.
- R3: Edges are counted from the first rising clock edge after the clock pad falls, numbered 0. If a bit is already valid when the pad falls, the data line changes at edge 4, the minimum hold, and never earlier.
- R4: A bit that becomes valid at edge m, where 4 ≤ m ≤ deadline, changes the data line at edge m without any clock stretch.
- R5: In standard mode (`fast_mode`=0), the deadline is edge 690. A bit valid at edge 690 is still placed without a stretch.
- R6: In fast mode (`fast_mode`=1), the deadline is edge 180. A bit valid at edge 180 is still placed without a stretch.
- R7: If no bit is valid at the deadline edge, `scl_drive_low` rises at that edge and stays 1 until the bit is taken.
- R8: After the data line changes during a stretch, `scl_drive_low` falls exactly 50 cycles later in standard mode and 20 cycles later in fast mode.
- R9: A `bit_valid` offered while the clock pad is high is ignored: the data line does not change and `bit_taken` stays 0.
- R10: `bit_taken` is a single-cycle pulse, high in exactly the cycle in which the data line takes the new bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_pad | input | 1 | Level seen on the clock wire |
| fast_mode | input | 1 | 1 selects fast-mode limits, 0 standard-mode |
| bit_valid | input | 1 | Upstream offers the next data bit |
| bit_value | input | 1 | Level of the offered bit |
| bit_taken | output | 1 | One-cycle pulse when the bit is put on the wire |
| sda_drive_low | output | 1 | Pull the data wire low |
| scl_drive_low | output | 1 | Pull the clock wire low (stretch) |

## Verification
At the hold deadline, two things compete for the same edge: placing the data bit and starting a clock stretch. The bench provokes this race by raising `bit_valid` exactly at the deadline edge and again one edge later, in both modes.

The scoreboard judges each case by edge index:
- **Bit valid at the deadline:** the data line must change at that edge and the clock must never be held.
- **Bit valid one edge later:** the clock hold must begin at the deadline, the data line must change one edge after it, and the release must follow after the setup count.

// File: rtl/sht_pkg.sv
package sht_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_STRETCH = 2'd2,
    ST_SETUP   = 2'd3
  } sht_state_e;

  // Bus timing limits in nanoseconds, per speed grade
  localparam longint unsigned LOW_STD_NS  = 64'd4700;
  localparam longint unsigned SU_STD_NS   = 64'd250;
  localparam longint unsigned RISE_STD_NS = 64'd1000;
  localparam longint unsigned LOW_FST_NS  = 64'd1300;
  localparam longint unsigned SU_FST_NS   = 64'd100;
  localparam longint unsigned RISE_FST_NS = 64'd300;

  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Rounds down: used for deadlines that must not be overshot
  function automatic int unsigned cyc_floor(longint unsigned hz, longint unsigned ns);
    return 32'((hz * ns) / NS_PER_S);
  endfunction

  // Rounds up: used for intervals that must be at least as long as stated
  function automatic int unsigned cyc_ceil(longint unsigned hz, longint unsigned ns);
    return 32'((hz * ns + NS_PER_S - 64'd1) / NS_PER_S);
  endfunction

endpackage

// File: rtl/sht_scl_sync.sv
module sht_scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pad,
  output logic scl_level,
  output logic scl_fall
);

  logic [STAGES:0] tap;
  logic            prev_q;

  assign tap[0] = scl_pad;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic stage_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q <= 1'b1;
      else        stage_q <= tap[gi];
    end
    assign tap[gi+1] = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= tap[STAGES];
  end

  assign scl_level = tap[STAGES];
  assign scl_fall  = prev_q & ~tap[STAGES];

endmodule

// File: rtl/sht_limits.sv
module sht_limits
  import sht_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 200_000_000,
  parameter int unsigned     CW     = 10
) (
  input  logic          fast_sel,
  output logic [CW-1:0] hold_max,
  output logic [CW-1:0] setup_cyc,
  output logic [CW-1:0] low_cyc
);

  localparam int unsigned HMAX_STD = cyc_floor(CLK_HZ, LOW_STD_NS - SU_STD_NS - RISE_STD_NS);
  localparam int unsigned HMAX_FST = cyc_floor(CLK_HZ, LOW_FST_NS - SU_FST_NS - RISE_FST_NS);
  localparam int unsigned SU_STD   = cyc_ceil(CLK_HZ, SU_STD_NS);
  localparam int unsigned SU_FST   = cyc_ceil(CLK_HZ, SU_FST_NS);
  localparam int unsigned LOW_STD  = cyc_floor(CLK_HZ, LOW_STD_NS);
  localparam int unsigned LOW_FST  = cyc_floor(CLK_HZ, LOW_FST_NS);

  always_comb begin
    if (fast_sel) begin
      hold_max  = CW'(HMAX_FST);
      setup_cyc = CW'(SU_FST);
      low_cyc   = CW'(LOW_FST);
    end else begin
      hold_max  = CW'(HMAX_STD);
      setup_cyc = CW'(SU_STD);
      low_cyc   = CW'(LOW_STD);
    end
  end

endmodule

// File: rtl/sht_ctrl.sv
module sht_ctrl
  import sht_pkg::*;
#(
  parameter int unsigned CW       = 10,
  parameter int unsigned LOAD     = 3,
  parameter int unsigned HOLD_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_level,
  input  logic          scl_fall,
  input  logic          fast_mode,
  input  logic          bit_valid,
  input  logic          bit_value,
  input  logic [CW-1:0] hold_max,
  input  logic [CW-1:0] setup_cyc,
  output logic          mode_q,
  output logic [CW-1:0] cnt_q,
  output logic          sda_low_q,
  output logic          scl_low_q,
  output logic          take_q
);

  sht_state_e    state_q, state_n;
  logic [CW-1:0] cnt_n;
  logic          sda_n, scl_n, take_n, mode_n;
  logic          cnt_en, mode_en;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sda_n   = sda_low_q;
    scl_n   = scl_low_q;
    take_n  = 1'b0;
    mode_n  = mode_q;
    mode_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (scl_fall) begin
          state_n = ST_WAIT;
          cnt_n   = CW'(LOAD);
          mode_n  = fast_mode;
          mode_en = 1'b1;
        end
      end
      ST_WAIT: begin
        if (scl_level) begin
          state_n = ST_IDLE;
        end else if (bit_valid && (cnt_q >= CW'(HOLD_MIN))) begin
          sda_n   = ~bit_value;
          take_n  = 1'b1;
          state_n = ST_IDLE;
        end else if (cnt_q >= hold_max) begin
          scl_n   = 1'b1;
          state_n = ST_STRETCH;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_STRETCH: begin
        if (bit_valid) begin
          sda_n   = ~bit_value;
          take_n  = 1'b1;
          state_n = ST_SETUP;
          cnt_n   = CW'(1);
        end
      end
      ST_SETUP: begin
        if (cnt_q >= setup_cyc) begin
          scl_n   = 1'b0;
          state_n = ST_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign cnt_en = (state_q != ST_IDLE) || scl_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sda_low_q <= 1'b0;
      scl_low_q <= 1'b0;
      take_q    <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      take_q    <= take_n;
      scl_low_q <= scl_n;
      if (cnt_en)  cnt_q     <= cnt_n;
      if (take_n)  sda_low_q <= sda_n;
      if (mode_en) mode_q    <= mode_n;
    end
  end

endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer
  import sht_pkg::*;
#(
  parameter longint unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned     SYNC_STAGES  = 2,
  parameter int unsigned     MIN_HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pad,
  input  logic fast_mode,
  input  logic bit_valid,
  input  logic bit_value,
  output logic bit_taken,
  output logic sda_drive_low,
  output logic scl_drive_low
);

  localparam int unsigned CW       = $clog2(cyc_ceil(CLK_HZ, LOW_STD_NS) + 2);
  localparam int unsigned LOAD     = SYNC_STAGES + 1;
  localparam int unsigned HOLD_MIN = (MIN_HOLD_CYC > LOAD) ? MIN_HOLD_CYC : LOAD;

  logic          rst_meta_q, rst_core_n;
  logic          scl_level, scl_fall, mode_q;
  logic [CW-1:0] hold_max, setup_cyc, low_cyc, cnt_q;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  sht_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_pad(scl_pad),
    .scl_level(scl_level), .scl_fall(scl_fall)
  );

  sht_limits #(.CLK_HZ(CLK_HZ), .CW(CW)) u_lim (
    .fast_sel(mode_q), .hold_max(hold_max),
    .setup_cyc(setup_cyc), .low_cyc(low_cyc)
  );

  sht_ctrl #(.CW(CW), .LOAD(LOAD), .HOLD_MIN(HOLD_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .scl_level(scl_level), .scl_fall(scl_fall),
    .fast_mode(fast_mode), .bit_valid(bit_valid), .bit_value(bit_value),
    .hold_max(hold_max), .setup_cyc(setup_cyc),
    .mode_q(mode_q), .cnt_q(cnt_q),
    .sda_low_q(sda_drive_low), .scl_low_q(scl_drive_low), .take_q(bit_taken)
  );

endmodule

// File: rtl/sht_checker.sv
module sht_checker #(
  parameter int unsigned CW = 10
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          scl_level,
  input logic          sda_drive_low,
  input logic          scl_drive_low,
  input logic          bit_taken,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] hold_max,
  input logic [CW-1:0] setup_cyc,
  input logic [CW-1:0] low_cyc
);

  assert_sda_low_phase_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_level));

  assert_sda_with_take_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sda_drive_low != $past(sda_drive_low)) |-> bit_taken);

  assert_take_pulse_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    bit_taken |=> !bit_taken);

  assert_stretch_deadline_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(scl_drive_low) |-> ($past(cnt_q) == $past(hold_max)));

  assert_release_setup_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(scl_drive_low) |-> ($past(cnt_q) == $past(setup_cyc)));

  assert_window_budget_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bit_taken && !scl_drive_low) |->
      (({1'b0, $past(cnt_q)} + {1'b0, setup_cyc}) <= {1'b0, low_cyc}));

endmodule

bind sda_hold_timer sht_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .scl_level(scl_level),
  .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low),
  .bit_taken(bit_taken), .cnt_q(cnt_q), .hold_max(hold_max),
  .setup_cyc(setup_cyc), .low_cyc(low_cyc)
);

// File: tb/tb_sda_hold_timer.sv
module tb_sda_hold_timer;

  logic clk = 1'b0;
  logic rst_n, ctrl_scl, fast_mode, bit_valid, bit_value;
  logic bit_taken, sda_drive_low, scl_drive_low, scl_bus;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic lvl;
    int   sda_at;
    int   st_at;
    int   rel_at;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign scl_bus = ctrl_scl & ~scl_drive_low;

  sda_hold_timer dut (
    .clk(clk), .rst_n(rst_n), .scl_pad(scl_bus), .fast_mode(fast_mode),
    .bit_valid(bit_valid), .bit_value(bit_value), .bit_taken(bit_taken),
    .sda_drive_low(sda_drive_low), .scl_drive_low(scl_drive_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Driver: one bit per clock low phase; valid offered at edge m
  task automatic run_bit(input logic val, input int m, input logic fast);
    exp_t e;
    int hm, su, lw, n;
    bit seen;
    hm = fast ? 180 : 690;
    su = fast ? 20 : 50;
    lw = fast ? 260 : 940;
    e.lvl    = ~val;
    e.sda_at = ((m > 4) ? m : 4) + 1;
    e.st_at  = (m > hm) ? hm + 1 : 0;
    e.rel_at = (m > hm) ? e.sda_at + su : 0;
    exp_q.push_back(e);
    @(negedge clk);
    fast_mode = fast;
    ctrl_scl  = 1'b0;
    if (m == 0) begin
      bit_valid = 1'b1;
      bit_value = val;
    end
    n = 0;
    seen = 0;
    while (!(seen && n >= lw)) begin
      @(posedge clk);
      n++;
      #1;
      if (bit_taken) seen = 1;
      @(negedge clk);
      if (seen) bit_valid = 1'b0;
      else if (n == m) begin
        bit_valid = 1'b1;
        bit_value = val;
      end
    end
    ctrl_scl = 1'b1;
    while (scl_drive_low) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  // Monitor: measures edge indices after each controller clock fall
  initial begin
    forever begin
      int n, sda_at, st_at, rel_at;
      bit done;
      exp_t e;
      @(negedge ctrl_scl);
      n = 0; sda_at = 0; st_at = 0; rel_at = 0; done = 0;
      while (!done && n < 3000) begin
        @(posedge clk);
        n++;
        #1;
        if (scl_drive_low && st_at == 0) st_at = n;
        if (st_at != 0 && rel_at == 0 && !scl_drive_low) rel_at = n;
        if (bit_taken && sda_at == 0) begin
          sda_at = n;
          check(sda_drive_low == exp_q[0].lvl, "R2 level", sda_drive_low, exp_q[0].lvl);
        end
        done = (sda_at != 0) && (st_at == 0 || rel_at != 0);
      end
      @(posedge clk);
      #1;
      check(!bit_taken, "R10 pulse width", bit_taken, 0);
      if (exp_q.size() == 0) begin
        check(0, "scoreboard empty", 0, 1);
      end else begin
        e = exp_q.pop_front();
        check(sda_at == e.sda_at, (e.st_at == 0) ? "R3/R4 sda edge" : "R7 sda edge", sda_at, e.sda_at);
        check(st_at == e.st_at, "R5/R6/R7 stretch onset", st_at, e.st_at);
        check(rel_at == e.rel_at, "R8 release edge", rel_at, e.rel_at);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctrl_scl = 1'b1; fast_mode = 1'b0;
    bit_valid = 1'b0; bit_value = 1'b0;
    repeat (5) @(negedge clk);
    check(!sda_drive_low && !scl_drive_low && !bit_taken, "R1 in reset",
          {sda_drive_low, scl_drive_low, bit_taken}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!sda_drive_low && !scl_drive_low && !bit_taken, "R1 after reset",
          {sda_drive_low, scl_drive_low, bit_taken}, 0);

    // R9: offer with the clock high; nothing may move
    bit_valid = 1'b1; bit_value = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (bit_taken || sda_drive_low) check(0, "R9 ignored while high", {sda_drive_low, bit_taken}, 0);
    end
    check(!sda_drive_low && !bit_taken, "R9 ignored while high", {sda_drive_low, bit_taken}, 0);
    bit_valid = 1'b0;
    repeat (5) @(negedge clk);

    run_bit(1'b0, 0,    1'b0);  // R3 minimum hold
    run_bit(1'b1, 100,  1'b0);  // R4
    run_bit(1'b0, 690,  1'b0);  // R5 valid at deadline
    run_bit(1'b1, 691,  1'b0);  // R7 R8 one past deadline
    run_bit(1'b0, 1000, 1'b0);  // R7 long stretch
    run_bit(1'b1, 2,    1'b1);  // R3 fast
    run_bit(1'b0, 180,  1'b1);  // R6 valid at deadline
    run_bit(1'b1, 181,  1'b1);  // R7 R8 fast
    run_bit(1'b0, 400,  1'b1);  // R7 fast long stretch
    run_bit(1'b1, 4,    1'b1);  // R4 exactly at minimum
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule